// File: doc/BRIEF.md
# Two-Device Termination Scheduler

This block sits inside a memory controller whose data channel is shared by the controller and two DDR2 memory devices. It accepts read and write commands, each tagged with the device it addresses. For every transfer it decides who terminates the data lines. The device that is not addressed raises its on-die termination pin. The controller switches on its own termination, coded as 75 ohms, only while it is receiving read data.

The termination window opens two clocks before the first data beat and closes two clocks after the last one. The first beat comes CAS latency plus additive latency clocks after acceptance for a read, and one clock earlier for a write. A burst of 4 or 8 beats occupies 2 or 4 clocks. The block also keeps a 2-bit image of each device's extended-mode termination field. It holds a device's pin low whenever that image reads "disabled", because a raised pin would then have no effect.

The block takes one command at a time. It raises `cmd_ready` again only after the current window has closed. It adds one more idle clock when the next command addresses the other device, because the terminating device changes.

Top module: `odt_sched`

## Requirements
- R1: While reset is held and in the first cycle after it, both ODT pins are low, `ctrl_rtt` is 00, `cmd_ready` is 1 and both termination images read 00.
- R2: A cycle with `emr_we` high writes `emr_rtt` into the image of device `emr_sel` (0 or 1), visible on `emr0_rtt`/`emr1_rtt` from the next cycle. The encoding is 00 disabled, 01 75 ohm, 10 150 ohm, 11 50 ohm.
- R3: During a transfer the addressed device's ODT pin stays low and the other device's pin carries the window. The two pins are never high together.
- R4: A device whose image reads 00 keeps its ODT pin low, including when it is the terminating device.
- R5: `ctrl_rtt` is 01 throughout a read window and 00 at all other times, so it is 00 for writes.
- R6: Latency is L = CL + AL for a read and L = CL + AL - 1 for a write. With the command accepted at clock edge a, the window covers cycles a+L-2 through a+L+B+1, where B is the burst in clocks.
- R7: B is 4 when `burst8` is 1 and 2 when it is 0, so a window lasts 8 or 6 cycles.
- R8: `cmd_ready` is low from the cycle after acceptance through the last window cycle.
- R9: In the first cycle after a window, `cmd_ready` is high only if `cmd_dev` equals the previous target. From the second cycle on, it is high for either device.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid | input | 1 | Command present |
| cmd_write | input | 1 | 1 write, 0 read |
| cmd_dev | input | 1 | Target device, 0 or 1 |
| cmd_ready | output | 1 | Command taken on an edge where valid and ready are both high |
| cas_lat | input | 3 | CAS latency, 3 to 6, sampled at acceptance |
| add_lat | input | AL_W | Additive latency, sampled at acceptance |
| burst8 | input | 1 | 1 for 8-beat bursts, 0 for 4-beat bursts |
| emr_we | input | 1 | Load a termination image |
| emr_sel | input | 1 | Device whose image is loaded |
| emr_rtt | input | 2 | Termination code to load |
| emr0_rtt | output | 2 | Termination image of device 0 |
| emr1_rtt | output | 2 | Termination image of device 1 |
| odt_pin | output | 2 | ODT pin per device, bit i for device i |
| ctrl_rtt | output | 2 | Controller termination code |

## Verification
The bench targets the smallest latency, a write with CL 3 and AL 0, where the window opens in the very cycle after acceptance. A design with an off-by-one start would open the window late, or would wrap its start index and miss the window entirely. It also runs commands back to back to the same device and to the other device. This exposes a scheduler that skips the turnaround cycle and lets two devices' windows abut, and one that stalls same-device traffic for no reason. Images loaded as disabled, including while a window is open, catch pins that are raised without any termination behind them. Random traffic mixing both burst lengths catches a window that is two clocks too long or too short.

// File: rtl/odt_sched.sv
module odt_sched #(
  parameter int AL_W  = 3,
  parameter int CNT_W = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cmd_valid,
  input  logic            cmd_write,
  input  logic            cmd_dev,
  output logic            cmd_ready,
  input  logic [2:0]      cas_lat,
  input  logic [AL_W-1:0] add_lat,
  input  logic            burst8,
  input  logic            emr_we,
  input  logic            emr_sel,
  input  logic [1:0]      emr_rtt,
  output logic [1:0]      emr0_rtt,
  output logic [1:0]      emr1_rtt,
  output logic [1:0]      odt_pin,
  output logic [1:0]      ctrl_rtt
);

  localparam logic [1:0] RTT_OFF = 2'b00;
  localparam logic [1:0] RTT_75  = 2'b01;

  logic             busy, gap, wr_q, dev_q;
  logic [CNT_W-1:0] cnt, open_q, close_q;
  logic [CNT_W-1:0] lat_w, open_w, close_w;
  logic [1:0]       emr_q [2];
  logic             accept, window;

  assign lat_w   = CNT_W'(cas_lat) + CNT_W'(add_lat) - CNT_W'(cmd_write);
  assign open_w  = lat_w - CNT_W'(2);
  assign close_w = lat_w + (burst8 ? CNT_W'(5) : CNT_W'(3));

  assign cmd_ready = !busy && !(gap && (cmd_dev != dev_q));
  assign accept    = cmd_valid && cmd_ready;
  assign window    = busy && (cnt >= open_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      gap     <= 1'b0;
      cnt     <= '0;
      open_q  <= '0;
      close_q <= '0;
      wr_q    <= 1'b0;
      dev_q   <= 1'b0;
    end else if (accept) begin
      busy    <= 1'b1;
      gap     <= 1'b0;
      cnt     <= '0;
      open_q  <= open_w;
      close_q <= close_w;
      wr_q    <= cmd_write;
      dev_q   <= cmd_dev;
    end else if (busy) begin
      if (cnt == close_q) begin
        busy <= 1'b0;
        gap  <= 1'b1;
      end else begin
        cnt <= cnt + CNT_W'(1);
      end
    end else begin
      gap <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      emr_q[0] <= RTT_OFF;
      emr_q[1] <= RTT_OFF;
    end else if (emr_we) begin
      emr_q[emr_sel] <= emr_rtt;
    end
  end

  assign emr0_rtt = emr_q[0];
  assign emr1_rtt = emr_q[1];

  for (genvar i = 0; i < 2; i++) begin : g_pin
    assign odt_pin[i] = window && (dev_q != 1'(i)) && (emr_q[i] != RTT_OFF);
  end

  assign ctrl_rtt = (window && !wr_q) ? RTT_75 : RTT_OFF;

  assert_one_terminator_R3: assert property (@(posedge clk) disable iff (rst)
    !(odt_pin[0] && odt_pin[1]));

  assert_busy_in_window_R8: assert property (@(posedge clk) disable iff (rst)
    ((odt_pin != 2'b00) || (ctrl_rtt != RTT_OFF)) |-> !cmd_ready);

  assert_ready_drops_R8: assert property (@(posedge clk) disable iff (rst)
    accept |=> !cmd_ready);

  assert_ctrl_code_R5: assert property (@(posedge clk) disable iff (rst)
    (ctrl_rtt == RTT_OFF) || (ctrl_rtt == RTT_75));

  assert_turnaround_R9: assert property (@(posedge clk) disable iff (rst)
    (accept && gap) |-> (cmd_dev == dev_q));

  assert_load0_R2: assert property (@(posedge clk) disable iff (rst)
    (emr_we && !emr_sel) |=> (emr0_rtt == $past(emr_rtt)));

  assert_load1_R2: assert property (@(posedge clk) disable iff (rst)
    (emr_we && emr_sel) |=> (emr1_rtt == $past(emr_rtt)));

endmodule

// File: tb/odt_sched_tb.sv
`timescale 1ns/1ps
module odt_sched_tb_top;
  logic clk = 1'b0;
  logic rst;
  logic cmd_valid, cmd_write, cmd_dev, burst8, emr_we, emr_sel;
  logic [2:0] cas_lat, add_lat;
  logic [1:0] emr_rtt;
  logic cmd_ready;
  logic [1:0] emr0_rtt, emr1_rtt, odt_pin, ctrl_rtt;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  bit m_have = 0;
  int m_acc, m_open, m_close;
  bit m_dev, m_wr;
  logic [1:0] m_emr [2];

  always #2 clk = ~clk;

  odt_sched dut_i (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_write(cmd_write),
    .cmd_dev(cmd_dev), .cmd_ready(cmd_ready), .cas_lat(cas_lat),
    .add_lat(add_lat), .burst8(burst8), .emr_we(emr_we), .emr_sel(emr_sel),
    .emr_rtt(emr_rtt), .emr0_rtt(emr0_rtt), .emr1_rtt(emr1_rtt),
    .odt_pin(odt_pin), .ctrl_rtt(ctrl_rtt));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s cycle %0d actual %0d expected %0d", req, cyc, act, exp);
    end
  endtask

  function automatic bit in_win();
    int rel = cyc - m_acc;
    return m_have && rel >= m_open && rel <= m_close;
  endfunction

  function automatic bit exp_rdy(input bit d);
    int rel = cyc - m_acc;
    if (!m_have) return 1;
    if (rel <= m_close) return 0;
    if (rel == m_close + 1 && d != m_dev) return 0;
    return 1;
  endfunction

  task automatic step(input bit v, input bit w, input bit d, input int cl, input int al,
                      input bit b8, input bit we, input bit sel, input logic [1:0] rtt,
                      output bit taken);
    logic [1:0] e_odt;
    bit win = in_win();
    e_odt[0] = win && m_dev != 1'b0 && m_emr[0] != 2'b00;
    e_odt[1] = win && m_dev != 1'b1 && m_emr[1] != 2'b00;
    chk("R3,R4,R6,R7 odt_pin", odt_pin, e_odt);
    chk("R5 ctrl_rtt", ctrl_rtt, (win && !m_wr) ? 1 : 0);
    chk("R2 emr0_rtt", emr0_rtt, m_emr[0]);
    chk("R2 emr1_rtt", emr1_rtt, m_emr[1]);
    cmd_valid = v; cmd_write = w; cmd_dev = d;
    cas_lat = 3'(cl); add_lat = 3'(al); burst8 = b8;
    emr_we = we; emr_sel = sel; emr_rtt = rtt;
    #1;
    chk("R8,R9 cmd_ready", cmd_ready, exp_rdy(d));
    taken = v && exp_rdy(d);
    if (taken) begin
      int lat = cl + al - (w ? 1 : 0);
      m_have = 1; m_acc = cyc + 1; m_dev = d; m_wr = w;
      m_open = lat - 2; m_close = lat + (b8 ? 4 : 2) + 1;
    end
    if (we) m_emr[sel] = rtt;
    @(negedge clk);
    cyc++;
  endtask

  task automatic idle(input int n);
    bit t;
    for (int i = 0; i < n; i++) step(0, 0, 0, 3, 0, 0, 0, 0, 2'b00, t);
  endtask

  task automatic load(input bit sel, input logic [1:0] rtt);
    bit t;
    step(0, 0, 0, 3, 0, 0, 1, sel, rtt, t);
  endtask

  task automatic issue(input bit w, input bit d, input int cl, input int al, input bit b8);
    bit t = 0;
    while (!t) step(1, w, d, cl, al, b8, 0, 0, 2'b00, t);
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog expired at cycle %0d", cyc);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    bit t;
    void'($urandom(32'h5EED_0D7));
    m_emr[0] = 2'b00; m_emr[1] = 2'b00;
    rst = 1; cmd_valid = 0; cmd_write = 0; cmd_dev = 0; cas_lat = 3; add_lat = 0;
    burst8 = 0; emr_we = 0; emr_sel = 0; emr_rtt = 0;
    repeat (3) @(negedge clk);
    // R1 during reset
    chk("R1 odt_pin", odt_pin, 0);
    chk("R1 ctrl_rtt", ctrl_rtt, 0);
    chk("R1 cmd_ready", cmd_ready, 1);
    chk("R1 emr0_rtt", emr0_rtt, 0);
    chk("R1 emr1_rtt", emr1_rtt, 0);
    rst = 0;
    load(0, 2'b11);
    load(1, 2'b11);
    // R6 smallest latency: write CL3 AL0, window opens right after acceptance
    issue(1, 0, 3, 0, 0);
    idle(9);
    // R5 read, R7 burst of 8
    issue(0, 1, 6, 4, 1);
    idle(16);
    // R9 same device back to back, then change of device
    issue(0, 0, 4, 0, 0);
    issue(1, 0, 4, 1, 1);
    issue(0, 1, 5, 0, 0);
    idle(12);
    // R4 disabled image while the window is open
    load(1, 2'b00);
    issue(0, 0, 3, 2, 1);
    idle(3);
    load(1, 2'b10);
    idle(10);
    for (int i = 0; i < 6000; i++) begin
      bit v  = ($urandom % 2) == 0;
      bit we = ($urandom % 16) == 0;
      step(v, 1'($urandom), 1'($urandom), 3 + int'($urandom % 4), int'($urandom % 5),
           1'($urandom), we, 1'($urandom), 2'($urandom), t);
    end
    idle(20);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule